// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the three control fields that steer a clock synthesizer's divider chain. The fields are a 7-bit feedback divide value, a 2-bit post-divide code and a 3-bit test-select code. Two paths can write them. The first is a parallel pin set that behaves like a level-gated latch. The second is a three-wire serial port made of a bit clock, a data line and a transfer strobe. The three active fields leave the block as plain registered outputs, and the divider logic uses them directly.

All inputs are synchronous to `clk`. The block finds edges on the parallel strobe, the serial clock and the transfer strobe by comparing each with its value in the previous cycle. The active fields therefore change one clock after the edge of `clk` that sampled the cause. A usual system sets the dividers from the parallel pins at power-up. It then raises the parallel strobe and retunes the dividers, or selects a test function, through the serial port. There is no streamed data path, so the block has no valid/ready handshake. Every pin is a plain level.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low, `fb_div`, `post_div` and `test_sel` are all zero, and the serial shift register is cleared to zero.
- R2: In every cycle where `par_hold` is sampled low, `fb_div` and `post_div` take the values of `fb_pin` and `post_pin` from that cycle, one clock later.
- R3: On the cycle where `par_hold` is first sampled high after being low, the pin values are captured. While `par_hold` stays high, later pin changes leave `fb_div` and `post_div` unchanged unless a serial transfer occurs.
- R4: While `par_hold` is high, each rising edge of `ser_clk` shifts `ser_dat` into a 12-bit register, and a held-high `ser_clk` shifts only once. The stream order is test field, then post-divide field, then feedback field, each sent most significant bit first. After 12 shifts the first bit sent sits at bit 11, the test field at bits 11:9, the post-divide field at bits 8:7 and the feedback field at bits 6:0.
- R5: Shifting alone changes no output. On the cycle where `ser_xfer` is sampled low after being high, with `par_hold` high, all three shifted fields become the active values one clock later.
- R6: `test_sel` is zero one clock after any cycle where `par_hold` is sampled low, and no pin of the parallel path can make it nonzero.
- R7: A transfer leaves the shift register unchanged, so another `ser_xfer` pulse with no new shifting applies the same three fields again.
- R8: While `par_hold` is low, `ser_clk` edges do not change the shift register and `ser_xfer` edges do not transfer.
- R9: If the parallel capture edge and a serial transfer edge fall in the same cycle, the serial values win for the feedback and post-divide fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_pin | input | 7 | Parallel feedback divide value |
| post_pin | input | 2 | Parallel post-divide code |
| par_hold | input | 1 | Low: latch open (pins pass through); rising: capture; high: hold and enable serial |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_dat | input | 1 | Serial data bit |
| ser_xfer | input | 1 | Serial transfer strobe, acts on its falling edge |
| fb_div | output | 7 | Active feedback divide value |
| post_div | output | 2 | Active post-divide code |
| test_sel | output | 3 | Active test-select code |

## Verification
The parallel path is driven with pin values that change while the latch is open, and again after capture. These patterns separate a path that passes pins through from one that holds them. Two serial words with different values in every field are shifted in. They expose any error in field order or bit order, and they show whether shifting alone leaks to the outputs. Serial traffic sent while the latch is open is followed by a transfer that uses the older contents, which shows the traffic was ignored. A transfer placed in the same cycle as a capture shows which path has priority.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int FB_W   = 7;
  localparam int POST_W = 2;
  localparam int TEST_W = 3;
  localparam int WORD_W = TEST_W + POST_W + FB_W;

  // test field is shifted first, so it ends in the top bits
  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [POST_W-1:0] post;
    logic [FB_W-1:0]   fb;
  } cfg_word_t;
endpackage

// File: rtl/divcfg_prev.sv
module divcfg_prev #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= RST_VAL[i];
      else        prev[i] <= cur[i];
    end
  end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift
  import divcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      sclk,
  input  logic      sclk_prev,
  input  logic      sdat,
  output cfg_word_t word
);
  logic step;
  assign step = enable && sclk && !sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (step) word <= {word[WORD_W-2:0], sdat};
  end

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sclk && !sclk_prev) |=> (word == {$past(word[WORD_W-2:0]), $past(sdat)}));
  // R8
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(word));
endmodule

// File: rtl/divcfg_active.sv
module divcfg_active
  import divcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              hold_prev,
  input  logic              xfer,
  input  logic              xfer_prev,
  input  logic [FB_W-1:0]   fb_in,
  input  logic [POST_W-1:0] post_in,
  input  cfg_word_t         shifted,
  output cfg_word_t         active
);
  logic take_pins, take_serial;
  assign take_pins   = !hold || (hold && !hold_prev);
  assign take_serial = hold && xfer_prev && !xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else begin
      if (take_pins) begin
        active.fb   <= fb_in;
        active.post <= post_in;
      end
      if (!hold) active.test <= '0;
      if (take_serial) active <= shifted;   // serial has priority
    end
  end

  // R6
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (active.test == '0));
  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (active.fb == $past(fb_in) && active.post == $past(post_in)));
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && hold_prev && !(xfer_prev && !xfer)) |=> $stable(active));
  // R5
  xfer_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && xfer_prev && !xfer) |=> (active == $past(shifted)));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FB_W-1:0]   fb_pin,
  input  logic [POST_W-1:0] post_pin,
  input  logic              par_hold,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_xfer,
  output logic [FB_W-1:0]   fb_div,
  output logic [POST_W-1:0] post_div,
  output logic [TEST_W-1:0] test_sel
);
  // bit 2: par_hold, bit 1: ser_clk, bit 0: ser_xfer
  // reset values chosen so no edge is seen on the first cycle
  localparam logic [2:0] PREV_RST = 3'b110;

  logic [2:0] lvl_now, lvl_prev;
  cfg_word_t  shifted, active;

  assign lvl_now = {par_hold, ser_clk, ser_xfer};

  divcfg_prev #(.W(3), .RST_VAL(PREV_RST)) u_prev (
    .clk(clk), .rst_n(rst_n), .cur(lvl_now), .prev(lvl_prev)
  );

  divcfg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .enable(par_hold),
    .sclk(ser_clk), .sclk_prev(lvl_prev[1]), .sdat(ser_dat), .word(shifted)
  );

  divcfg_active u_active (
    .clk(clk), .rst_n(rst_n), .hold(par_hold), .hold_prev(lvl_prev[2]),
    .xfer(ser_xfer), .xfer_prev(lvl_prev[0]),
    .fb_in(fb_pin), .post_in(post_pin), .shifted(shifted), .active(active)
  );

  assign fb_div   = active.fb;
  assign post_div = active.post;
  assign test_sel = active.test;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (fb_div == '0 && post_div == '0 && test_sel == '0));
endmodule

// File: tb/tb_divcfg_loader.sv
module tb_divcfg_loader;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] fb_pin = '0;
  logic [1:0] post_pin = '0;
  logic       par_hold = 0, ser_clk = 0, ser_dat = 0, ser_xfer = 0;
  logic [6:0] fb_div;
  logic [1:0] post_div;
  logic [2:0] test_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divcfg_loader dut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect3(string req, logic [6:0] fb, logic [1:0] pd, logic [2:0] ts);
    checks++;
    if (fb_div !== fb || post_div !== pd || test_sel !== ts) begin
      errors++;
      $display("FAIL %s: got fb=%0d post=%0d test=%0d, expected fb=%0d post=%0d test=%0d",
               req, fb_div, post_div, test_sel, fb, pd, ts);
    end
  endtask

  task automatic shift_word(logic [2:0] t, logic [1:0] n, logic [6:0] m);
    logic [11:0] w;
    w = {t, n, m};
    for (int i = 11; i >= 0; i--) begin
      ser_dat = w[i]; ser_clk = 1; tick();
      tick();               // held high: must not shift twice
      ser_clk = 0; tick();
    end
  endtask

  task automatic pulse_xfer();
    ser_xfer = 1; tick();
    ser_xfer = 0; tick();
  endtask

  task automatic t_reset();
    tick();
    expect3("R1 reset", 7'd0, 2'd0, 3'd0);
    rst_n = 1; tick();
    expect3("R1 after release", 7'd0, 2'd0, 3'd0);
  endtask

  task automatic t_pass();
    fb_pin = 7'd5; post_pin = 2'd2; tick();
    expect3("R2 open latch", 7'd5, 2'd2, 3'd0);
    fb_pin = 7'd100; post_pin = 2'd1; tick();
    expect3("R2 open latch change", 7'd100, 2'd1, 3'd0);
  endtask

  task automatic t_capture();
    fb_pin = 7'd48; post_pin = 2'd0; par_hold = 1; tick();
    expect3("R3 capture", 7'd48, 2'd0, 3'd0);
    fb_pin = 7'd3; post_pin = 2'd3; tick(); tick();
    expect3("R3 hold", 7'd48, 2'd0, 3'd0);
  endtask

  task automatic t_serial();
    shift_word(3'd5, 2'd3, 7'h55);
    expect3("R5 shift only", 7'd48, 2'd0, 3'd0);
    pulse_xfer();
    expect3("R4 R5 transfer", 7'h55, 2'd3, 3'd5);
  endtask

  task automatic t_test_clear_and_reapply();
    par_hold = 0; fb_pin = 7'd9; post_pin = 2'd1; tick();
    expect3("R6 test cleared", 7'd9, 2'd1, 3'd0);
    par_hold = 1; tick();
    expect3("R6 parallel capture, test stays zero", 7'd9, 2'd1, 3'd0);
    pulse_xfer();
    expect3("R7 reapply", 7'h55, 2'd3, 3'd5);
  endtask

  task automatic t_ignored();
    par_hold = 0; fb_pin = 7'd17; post_pin = 2'd2; tick();
    shift_word(3'd2, 2'd1, 7'h2A);
    pulse_xfer();
    expect3("R8 ignored while open", 7'd17, 2'd2, 3'd0);
    par_hold = 1; tick();
    pulse_xfer();
    expect3("R8 old contents kept", 7'h55, 2'd3, 3'd5);
  endtask

  task automatic t_second_word();
    shift_word(3'd2, 2'd1, 7'h2A);
    pulse_xfer();
    expect3("R4 second word", 7'h2A, 2'd1, 3'd2);
  endtask

  task automatic t_collision();
    par_hold = 0; fb_pin = 7'd64; post_pin = 2'd0; ser_xfer = 1; tick();
    expect3("R9 setup", 7'd64, 2'd0, 3'd0);
    par_hold = 1; ser_xfer = 0; tick();
    expect3("R9 serial wins", 7'h2A, 2'd1, 3'd2);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_capture();
    t_serial();
    t_test_clear_and_reapply();
    t_ignored();
    t_second_word();
    t_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule